// File: doc/BRIEF.md
# AXI Transaction Throughput and Latency Monitor

This block watches one AXI interface and never drives it. All of its bus-side pins are inputs. It turns the address, data and response handshakes into six event counters. From these counters software can derive average bandwidth and average latency, with writes and reads kept apart.

For each direction the monitor keeps three totals:
- bytes moved,
- transactions completed,
- the sum of the per-transaction latencies.

Dividing the byte total by elapsed time gives throughput. Dividing the latency sum by the transaction count gives average latency.

Latency is measured with a small in-order queue of timestamps per direction, one timestamp for each accepted address. A free-running cycle counter supplies the timestamps. When a transaction completes, the oldest timestamp in the queue is retired. A level enable gates all counting, and a one-cycle clear zeroes the counters. A 3-bit selector reads any one counter out combinationally.

Top module: `axi_perf_probe`

## Requirements
- R1: After reset all six counters read zero and `ovf_err` is low.
- R2: Each write-data handshake (`wvalid` and `wready` both high in one cycle) adds DATA_BYTES to the write byte count (selector code 0). Beats where only one of the two is high add nothing. The strobes are not observed.
- R3: Each write-response handshake (`bvalid` and `bready`) adds one to the write transaction count (selector code 1).
- R4: A write-response handshake adds to the write latency sum (selector code 2). The amount is the number of clock edges since the oldest pending write-address handshake, and that entry is retired, so entries are matched in order. A response with no pending entry adds 0.
- R5: Each read-data handshake (`rvalid` and `rready`) adds DATA_BYTES to the read byte count (selector code 3).
- R6: Each read-data handshake with `rlast` high adds one to the read transaction count (selector code 4).
- R7: A last-beat read handshake adds to the read latency sum (selector code 5). The amount is the number of edges since the oldest pending read-address handshake, and that entry is retired. With no pending entry it adds 0.
- R8: Each direction holds at most DEPTH (8) pending address timestamps. An address handshake that arrives when the queue is full, and no completion happens in the same cycle, is dropped. It also sets `ovf_err`, which then stays high until reset.
- R9: While `enable` is low the counters hold their values. Timestamp tracking continues while `enable` is low.
- R10: `clear` high at an edge sets all six counters to zero at that edge. It wins over any event in the same cycle.
- R11: A counter that would pass 2^CNT_W-1 stays at 2^CNT_W-1 instead of wrapping.
- R12: `rd_data` shows the counter chosen by `rd_sel` in the same cycle. Codes 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Counting enable |
| clear | input | 1 | Synchronous zeroing of all counters |
| awvalid | input | 1 | Observed write address valid |
| awready | input | 1 | Observed write address ready |
| wvalid | input | 1 | Observed write data valid |
| wready | input | 1 | Observed write data ready |
| bvalid | input | 1 | Observed write response valid |
| bready | input | 1 | Observed write response ready |
| arvalid | input | 1 | Observed read address valid |
| arready | input | 1 | Observed read address ready |
| rvalid | input | 1 | Observed read data valid |
| rready | input | 1 | Observed read data ready |
| rlast | input | 1 | Observed read data last flag |
| rd_sel | input | 3 | Counter select |
| rd_data | output | CNT_W | Selected counter value |
| ovf_err | output | 1 | Sticky timestamp queue overflow |

## Verification
The collisions of interest are an address handshake and a completion in the same cycle, and a clear that arrives with counting events. The first matters most when the queue is already full: the push must then be accepted, not flagged as overflow. The bench drives all handshake pins from a pseudo-random source, with periodic clears, and steers the address rate so that queues fill while completions are landing. A behavioural model built on queues predicts every counter and the error flag each cycle, so a same-cycle push and pop, or a clear that loses to an event, shows up as a mismatch in the edge where it occurs.

// File: rtl/apm_pkg.sv
package apm_pkg;

  localparam int NUM_CNT = 6;

  typedef enum logic [2:0] {
    SEL_WBYTES = 3'd0,
    SEL_WTXN   = 3'd1,
    SEL_WLAT   = 3'd2,
    SEL_RBYTES = 3'd3,
    SEL_RTXN   = 3'd4,
    SEL_RLAT   = 3'd5
  } cnt_sel_e;

  // Saturating add of two values limited to w bits.
  function automatic logic [63:0] sat_add(input logic [63:0] a,
                                          input logic [63:0] b,
                                          input int          w);
    logic [63:0] lim;
    logic [63:0] sum;
    lim = (64'd1 << w) - 64'd1;
    sum = a + b;
    return (sum > lim) ? lim : sum;
  endfunction

endpackage

// File: rtl/ts_queue.sv
module ts_queue #(
  parameter int DEPTH = 8,
  parameter int TS_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [TS_W-1:0] now,
  output logic [TS_W-1:0] latency,
  output logic            err
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_P  = PW'(DEPTH - 1);

  logic [TS_W-1:0] mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;
  logic            empty, full, pop_ok, push_ok, ovf_evt;

  assign empty   = (cnt == '0);
  assign full    = (cnt == DEPTH_C);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign ovf_evt = push && !push_ok;
  assign latency = empty ? '0 : (now - mem[rp]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      err <= 1'b0;
    end else begin
      if (push_ok) wp <= (wp == LAST_P) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == LAST_P) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
      if (ovf_evt) err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= now;
  end

  a_r8_ovf_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> err);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W     = 32,
  parameter int AMT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             inc_valid,
  input  logic [AMT_W-1:0] inc_amt,
  output logic [W-1:0]     q
);
  import apm_pkg::*;
  localparam logic [W-1:0] MAXV = '1;

  logic [63:0] nxt;
  assign nxt = sat_add(64'(q), 64'(inc_amt), W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (clr)              q <= '0;
    else if (en && inc_valid)  q <= nxt[W-1:0];
  end

  a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
  a_r9_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(q));
  a_r11_stays_max: assert property (@(posedge clk) disable iff (!rst_n)
    ((q == MAXV) && !clr) |=> (q == MAXV));
endmodule

// File: rtl/axi_perf_probe.sv
module axi_perf_probe #(
  parameter int CNT_W      = 32,
  parameter int TS_W       = 16,
  parameter int DATA_BYTES = 8,
  parameter int DEPTH      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic             awvalid,
  input  logic             awready,
  input  logic             wvalid,
  input  logic             wready,
  input  logic             bvalid,
  input  logic             bready,
  input  logic             arvalid,
  input  logic             arready,
  input  logic             rvalid,
  input  logic             rready,
  input  logic             rlast,
  input  logic [2:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             ovf_err
);
  import apm_pkg::*;
  localparam logic [TS_W-1:0] BEAT_AMT = TS_W'(DATA_BYTES);

  // Named handshake events
  logic aw_hs, w_hs, b_hs, ar_hs, r_hs, rlast_hs;
  assign aw_hs    = awvalid && awready;
  assign w_hs     = wvalid  && wready;
  assign b_hs     = bvalid  && bready;
  assign ar_hs    = arvalid && arready;
  assign r_hs     = rvalid  && rready;
  assign rlast_hs = r_hs && rlast;

  logic [TS_W-1:0] now_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  logic [TS_W-1:0] wr_lat, rd_lat;
  logic            wr_err, rd_err;

  ts_queue #(.DEPTH(DEPTH), .TS_W(TS_W)) u_wq (
    .clk(clk), .rst_n(rst_n), .push(aw_hs), .pop(b_hs),
    .now(now_q), .latency(wr_lat), .err(wr_err));

  ts_queue #(.DEPTH(DEPTH), .TS_W(TS_W)) u_rq (
    .clk(clk), .rst_n(rst_n), .push(ar_hs), .pop(rlast_hs),
    .now(now_q), .latency(rd_lat), .err(rd_err));

  assign ovf_err = wr_err || rd_err;

  logic            inc_v [NUM_CNT];
  logic [TS_W-1:0] inc_a [NUM_CNT];
  logic [CNT_W-1:0] cnt_q [NUM_CNT];

  always_comb begin
    inc_v[SEL_WBYTES] = w_hs;     inc_a[SEL_WBYTES] = BEAT_AMT;
    inc_v[SEL_WTXN]   = b_hs;     inc_a[SEL_WTXN]   = TS_W'(1);
    inc_v[SEL_WLAT]   = b_hs;     inc_a[SEL_WLAT]   = wr_lat;
    inc_v[SEL_RBYTES] = r_hs;     inc_a[SEL_RBYTES] = BEAT_AMT;
    inc_v[SEL_RTXN]   = rlast_hs; inc_a[SEL_RTXN]   = TS_W'(1);
    inc_v[SEL_RLAT]   = rlast_hs; inc_a[SEL_RLAT]   = rd_lat;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    sat_counter #(.W(CNT_W), .AMT_W(TS_W)) u_c (
      .clk(clk), .rst_n(rst_n), .en(enable), .clr(clear),
      .inc_valid(inc_v[g]), .inc_amt(inc_a[g]), .q(cnt_q[g]));
  end

  always_comb begin
    rd_data = '0;
    if (rd_sel < 3'(NUM_CNT)) rd_data = cnt_q[rd_sel];
  end

  a_r3_txn_counts_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (b_hs && enable && !clear && (g_cnt[1].u_c.q != '1))
      |=> (g_cnt[1].u_c.q == $past(g_cnt[1].u_c.q) + 1'b1));
  a_r6_rtxn_counts_last: assert property (@(posedge clk) disable iff (!rst_n)
    (r_hs && !rlast && enable && !clear) |=> $stable(g_cnt[4].u_c.q));
endmodule

// File: tb/axi_perf_probe_test.sv
`timescale 1ns/100ps
module axi_perf_probe_test;
  localparam int CW   = 10;
  localparam int DB   = 8;
  localparam int DEP  = 8;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, enable, clear;
  logic awvalid, awready, wvalid, wready, bvalid, bready;
  logic arvalid, arready, rvalid, rready, rlast;
  logic [2:0] rd_sel;
  logic [CW-1:0] rd_data;
  logic ovf_err;

  axi_perf_probe #(.CNT_W(CW), .TS_W(16), .DATA_BYTES(DB), .DEPTH(DEP)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
    .awvalid(awvalid), .awready(awready), .wvalid(wvalid), .wready(wready),
    .bvalid(bvalid), .bready(bready), .arvalid(arvalid), .arready(arready),
    .rvalid(rvalid), .rready(rready), .rlast(rlast),
    .rd_sel(rd_sel), .rd_data(rd_data), .ovf_err(ovf_err));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int m_cnt [6];
  int wq[$], rq[$];
  bit m_err;
  int cyc;
  int unsigned seed = 32'h1234_5678;
  bit last_clr, last_en;

  function automatic int sat(int a, int b);
    return (a + b > MAXV) ? MAXV : a + b;
  endfunction

  function automatic int unsigned rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic idle_inputs();
    awvalid = 0; awready = 0; wvalid = 0; wready = 0; bvalid = 0; bready = 0;
    arvalid = 0; arready = 0; rvalid = 0; rready = 0; rlast = 0;
  endtask

  task automatic compare_all();
    string tags [8] = '{"R2", "R3", "R4", "R5", "R6", "R7", "R12", "R12"};
    for (int s = 0; s < 8; s++) begin
      string t;
      int exp;
      rd_sel = 3'(s);
      #0.1;
      exp = (s < 6) ? m_cnt[s] : 0;
      if (s >= 6) t = tags[s];
      else if (last_clr) t = "R10";
      else if (!last_en) t = "R9";
      else if (exp == MAXV) t = "R11";
      else t = tags[s];
      check(t, int'(rd_data), exp);
    end
    check("R8", int'(ovf_err), int'(m_err));
  endtask

  // Model one edge from the currently applied inputs, then compare after it.
  task automatic tick();
    bit aw, w, b, ar, r, rl;
    int wl, rlat;
    aw = awvalid & awready; w = wvalid & wready; b = bvalid & bready;
    ar = arvalid & arready; r = rvalid & rready; rl = r & rlast;
    wl = 0; rlat = 0;
    if (b && wq.size() > 0) wl = cyc - wq.pop_front();
    if (aw) begin if (wq.size() < DEP) wq.push_back(cyc); else m_err = 1; end
    if (rl && rq.size() > 0) rlat = cyc - rq.pop_front();
    if (ar) begin if (rq.size() < DEP) rq.push_back(cyc); else m_err = 1; end
    if (clear) begin
      for (int k = 0; k < 6; k++) m_cnt[k] = 0;
    end else if (enable) begin
      if (w)  m_cnt[0] = sat(m_cnt[0], DB);
      if (b)  m_cnt[1] = sat(m_cnt[1], 1);
      if (b)  m_cnt[2] = sat(m_cnt[2], wl);
      if (r)  m_cnt[3] = sat(m_cnt[3], DB);
      if (rl) m_cnt[4] = sat(m_cnt[4], 1);
      if (rl) m_cnt[5] = sat(m_cnt[5], rlat);
    end
    last_clr = clear; last_en = enable;
    cyc++;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic rand_inputs(int aw_pct, int b_pct);
    awvalid = (rnd() % 100) < aw_pct; awready = rnd() % 4 != 0;
    wvalid  = rnd() % 2 == 0;         wready  = rnd() % 3 != 0;
    bvalid  = (rnd() % 100) < b_pct;  bready  = rnd() % 4 != 0;
    arvalid = (rnd() % 100) < aw_pct; arready = rnd() % 4 != 0;
    rvalid  = rnd() % 2 == 0;         rready  = rnd() % 3 != 0;
    rlast   = rnd() % 3 == 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) m_cnt[k] = 0;
    m_err = 0; cyc = 0; last_clr = 0; last_en = 1;
    rst_n = 0; enable = 1; clear = 0; rd_sel = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    for (int s = 0; s < 6; s++) begin
      rd_sel = 3'(s); #0.1; check("R1", int'(rd_data), 0);
    end
    check("R1", int'(ovf_err), 0);

    // Directed writes: staggered latency, then queue overflow (R8)
    for (int i = 0; i < 9; i++) begin
      idle_inputs(); awvalid = 1; awready = (i != 3); wvalid = 1; wready = 1;
      tick();
    end
    idle_inputs(); awvalid = 1; awready = 1; tick();
    for (int i = 0; i < 10; i++) begin
      idle_inputs(); bvalid = 1; bready = (i % 2 == 0) || (i > 4); tick();
    end
    // Directed reads with last beat and non-last beats (R6, R7)
    for (int i = 0; i < 4; i++) begin
      idle_inputs(); arvalid = 1; arready = 1; tick();
    end
    for (int i = 0; i < 12; i++) begin
      idle_inputs(); rvalid = 1; rready = 1; rlast = (i % 3 == 2);
      arvalid = (i == 5); arready = 1; tick();
    end
    // Push and pop together while full
    for (int i = 0; i < 8; i++) begin
      idle_inputs(); awvalid = 1; awready = 1; tick();
    end
    idle_inputs(); awvalid = 1; awready = 1; bvalid = 1; bready = 1; tick();
    // Clear colliding with events (R10)
    idle_inputs(); wvalid = 1; wready = 1; bvalid = 1; bready = 1; clear = 1; tick();
    clear = 0;

    // Random traffic with periodic clears and enable gaps (R9, R10)
    for (int i = 0; i < 2400; i++) begin
      rand_inputs(30, 35);
      clear  = (i % 97 == 50);
      enable = ((i / 150) % 4) != 3;
      tick();
    end
    // Saturation run (R11)
    clear = 0; enable = 1;
    for (int i = 0; i < 600; i++) begin
      rand_inputs(45, 45);
      tick();
    end
    idle_inputs(); tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule